// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block brings up an HD44780-compatible character display over its 8-bit parallel bus and then leaves it showing a fixed message. After a power-up pause it steps through a 24-entry table held in logic: four setup instructions, nineteen character writes and a final instruction that shifts the whole display one place to the left. Each table entry is 10 bits wide. Its two upper bits choose between an instruction and a character write, and its lower byte is the value placed on the data bus.

A single enable-pulse engine serves every entry. It places the register-select, read/write and data lines one cycle before the enable line rises. It holds enable high for a programmable number of clocks and then drops it while the bus stays put. It then waits a programmable settle time before the next entry. The settle time is long after the clear and return-home instructions and short after everything else. Once the last entry has settled, the block raises `done`, keeps enable low and ignores the clock until the next synchronous reset. All timings are given as clock-cycle counts, so the defaults (power-up 2,000,000, enable 25, short 2,000, long 80,000) suit a 50 MHz clock.

Top module: `lcd_seq_top`

## Requirements
- R1: A synchronous active-high reset makes `lcdE`, `done`, `lcdRs`, `lcdRw` and `lcdData` all zero from the clock edge that samples it.
- R2: After reset is released, the first rising edge of `lcdE` is seen exactly PWR_CYC+2 clock edges later.
- R3: Entry bits [9:8] drive `lcdRs` and `lcdRw`, and bits [7:0] drive `lcdData`. Prefix 2'b00 is an instruction (rs=0, rw=0). Prefix 2'b10 is a character write (rs=1, rw=0). `lcdRw` is never 1.
- R4: Entries 0 to 3 are the instructions 0x3C, 0x0C, 0x01 and 0x02, issued in that order.
- R5: Entries 4 to 22 are character writes of the ASCII string "Hello From FPGA Lab", first character first, with 0x20 for each space.
- R6: Entry 23 is the instruction 0x18 (shift the display left).
- R7: Each entry raises `lcdE` for exactly EN_CYC clock cycles. `lcdRs`, `lcdRw` and `lcdData` already hold the entry's value one cycle before `lcdE` rises.
- R8: `lcdRs`, `lcdRw` and `lcdData` stay unchanged while `lcdE` is high and in the cycle after it falls.
- R9: From the fall of `lcdE` to the next rise there are LONG_CYC+2 cycles when the entry just issued was an instruction with byte 0x01 to 0x03, and SHORT_CYC+2 cycles otherwise.
- R10: `done` rises SHORT_CYC cycles after the last entry's `lcdE` fall. It then stays high with `lcdE` low and the bus unchanged until reset, so exactly 24 pulses are issued.
- R11: A reset applied at any point, including in the middle of an enable pulse or after `done`, restarts the full power-up wait and the table from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lcdRs | output | 1 | Register select: 0 for an instruction, 1 for character data |
| lcdRw | output | 1 | Read/write select, always write (0) |
| lcdE | output | 1 | Enable strobe to the display |
| lcdData | output | 8 | Parallel data byte |
| done | output | 1 | High once the whole table has been issued |

## Verification
Two pairs of events can land in the same cycle. The first is the pointer step at the end of the final settle time, which meets the terminal-entry decision and must raise `done` without a twenty-fifth pulse. The second is a reset that arrives while the enable engine is mid-pulse. The first case is reached by running the table to its end: `done` must appear exactly SHORT_CYC cycles after the last fall, and no further enable edge may follow. The second is provoked by asserting reset two cycles into the first pulse of a fresh run. Enable and the bus must clear on the next edge, and the restart must again show the full power-up wait before entry 0.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int ENTRIES     = 24;
  localparam int PTR_W       = $clog2(ENTRIES + 1);
  localparam int SETUP_LEN   = 4;
  localparam int GREET_LEN   = 19;
  localparam int GREET_LAST  = SETUP_LEN + GREET_LEN - 1;
  localparam logic [8*GREET_LEN-1:0] GREETING = "Hello From FPGA Lab";

  // Prefixes in bits [9:8]: {rs, rw}
  localparam logic [1:0] KIND_INSTR = 2'b00;
  localparam logic [1:0] KIND_CHAR  = 2'b10;

  typedef struct packed {
    logic loadBus;     // latch table entry at pointer onto the bus
    logic armEnable;   // raise E, start enable-width timer
    logic dropEnable;  // lower E, start settle timer
    logic advance;     // step pointer to next entry
  } seqStrobes_t;

  function automatic logic [9:0] tableEntry(input logic [PTR_W-1:0] idx);
    int i;
    logic [9:0] e;
    i = int'(idx);
    if (i < SETUP_LEN) begin
      case (i)
        0:       e = {KIND_INSTR, 8'h3C};
        1:       e = {KIND_INSTR, 8'h0C};
        2:       e = {KIND_INSTR, 8'h01};
        default: e = {KIND_INSTR, 8'h02};
      endcase
    end else if (i <= GREET_LAST) begin
      e = {KIND_CHAR, GREETING[8*(GREET_LAST - i) +: 8]};
    end else if (i == ENTRIES - 1) begin
      e = {KIND_INSTR, 8'h18};
    end else begin
      e = '0;
    end
    return e;
  endfunction

endpackage

// File: rtl/lcd_seq_datapath.sv
module lcd_seq_datapath
  import lcd_seq_pkg::*;
#(
  parameter int PWR_CYC   = 2000000,
  parameter int EN_CYC    = 25,
  parameter int SHORT_CYC = 2000,
  parameter int LONG_CYC  = 80000
) (
  input  logic        clk,
  input  logic        rst,
  input  seqStrobes_t stb,
  output logic        timerZero,
  output logic        lastEntry,
  output logic        lcdRs,
  output logic        lcdRw,
  output logic        lcdE,
  output logic [7:0]  lcdData
);

  localparam int MAX_AB  = (PWR_CYC > EN_CYC) ? PWR_CYC : EN_CYC;
  localparam int MAX_CD  = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] timer;
  logic [PTR_W-1:0] ptr;
  logic             longSettle;

  // clear and return-home instructions need the long settle time
  assign longSettle = !lcdRs && (lcdData[7:2] == 6'd0) && (lcdData[1:0] != 2'd0);
  assign timerZero  = (timer == '0);
  assign lastEntry  = (ptr == PTR_W'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (rst)
      timer <= TMR_W'(PWR_CYC - 1);
    else if (stb.armEnable)
      timer <= TMR_W'(EN_CYC - 1);
    else if (stb.dropEnable)
      timer <= longSettle ? TMR_W'(LONG_CYC - 1) : TMR_W'(SHORT_CYC - 1);
    else if (!timerZero)
      timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (stb.advance && ptr != PTR_W'(ENTRIES))
      ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      {lcdRs, lcdRw, lcdData} <= '0;
    else if (stb.loadBus)
      {lcdRs, lcdRw, lcdData} <= tableEntry(ptr);
  end

  always_ff @(posedge clk) begin
    if (rst)
      lcdE <= 1'b0;
    else if (stb.armEnable)
      lcdE <= 1'b1;
    else if (stb.dropEnable)
      lcdE <= 1'b0;
  end

  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_W'(ENTRIES));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lcdE |=> $stable({lcdRs, lcdRw, lcdData}));

  // R3
  write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !lcdRw);

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        timerZero,
  input  logic        lastEntry,
  output seqStrobes_t stb,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_POWER, ST_LOAD, ST_ARM, ST_PULSE, ST_SETTLE, ST_DONE
  } seqState_t;

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_POWER;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_POWER:  if (timerZero) nextState = ST_LOAD;
      ST_LOAD: begin
        stb.loadBus = 1'b1;
        nextState   = ST_ARM;
      end
      ST_ARM: begin
        stb.armEnable = 1'b1;
        nextState     = ST_PULSE;
      end
      ST_PULSE: if (timerZero) begin
        stb.dropEnable = 1'b1;
        nextState      = ST_SETTLE;
      end
      ST_SETTLE: if (timerZero) begin
        stb.advance = 1'b1;
        nextState   = lastEntry ? ST_DONE : ST_LOAD;
      end
      default: nextState = ST_DONE;
    endcase
  end

  assign done = (state == ST_DONE);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R7
  load_before_arm_chk: assert property (@(posedge clk) disable iff (rst)
    stb.armEnable |-> $past(stb.loadBus));

endmodule

// File: rtl/lcd_seq_top.sv
module lcd_seq_top
  import lcd_seq_pkg::*;
#(
  parameter int PWR_CYC   = 2000000,
  parameter int EN_CYC    = 25,
  parameter int SHORT_CYC = 2000,
  parameter int LONG_CYC  = 80000
) (
  input  logic       clk,
  input  logic       rst,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdE,
  output logic [7:0] lcdData,
  output logic       done
);

  seqStrobes_t stb;
  logic        timerZero;
  logic        lastEntry;

  lcd_seq_ctrl ctrl (
    .clk       (clk),
    .rst       (rst),
    .timerZero (timerZero),
    .lastEntry (lastEntry),
    .stb       (stb),
    .done      (done)
  );

  lcd_seq_datapath #(
    .PWR_CYC   (PWR_CYC),
    .EN_CYC    (EN_CYC),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) dpath (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .timerZero (timerZero),
    .lastEntry (lastEntry),
    .lcdRs     (lcdRs),
    .lcdRw     (lcdRw),
    .lcdE      (lcdE),
    .lcdData   (lcdData)
  );

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !lcdE);

endmodule

// File: tb/lcd_seq_top_test.sv
`timescale 1ns/1ps
module lcd_seq_top_test;

  localparam int PWR   = 30;
  localparam int EN    = 4;
  localparam int SHORT = 6;
  localparam int LONG  = 15;
  localparam int LIMIT = 5000;

  // expected entries {rs, rw, data}
  localparam logic [9:0] EXP_TAB [24] = '{
    10'h03C, 10'h00C, 10'h001, 10'h002,
    10'h248, 10'h265, 10'h26C, 10'h26C, 10'h26F, 10'h220,
    10'h246, 10'h272, 10'h26F, 10'h26D, 10'h220,
    10'h246, 10'h250, 10'h247, 10'h241, 10'h220,
    10'h24C, 10'h261, 10'h262,
    10'h018
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lcdRs, lcdRw, lcdE, done;
  logic [7:0] lcdData;
  logic [9:0] bus;
  logic [9:0] prevBus;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;
  assign bus = {lcdRs, lcdRw, lcdData};

  lcd_seq_top #(
    .PWR_CYC(PWR), .EN_CYC(EN), .SHORT_CYC(SHORT), .LONG_CYC(LONG)
  ) uut (
    .clk(clk), .rst(rst), .lcdRs(lcdRs), .lcdRw(lcdRw),
    .lcdE(lcdE), .lcdData(lcdData), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic countUntilE(output int n);
    n = 0;
    do begin
      prevBus = bus;
      @(negedge clk);
      n++;
    end while (!lcdE && n < LIMIT);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    int w;
    int g;
    int dly;
    bit steady;
    int ePulses;
    int doneCnt;

    repeat (3) @(negedge clk);
    check("R1 enable after reset", lcdE, 0);
    check("R1 done after reset", done, 0);
    check("R1 bus after reset", bus, 0);

    rst = 1'b0;
    countUntilE(n);
    check("R2 power-up wait", n, PWR + 2);

    for (int i = 0; i < 24; i++) begin
      string tag;
      tag = (i < 4) ? "R4 setup entry" : (i < 23) ? "R5 greeting entry" : "R6 shift entry";
      check("R3 rs/rw prefix", {lcdRs, lcdRw}, EXP_TAB[i][9:8]);
      check(tag, lcdData, EXP_TAB[i][7:0]);
      check("R7 bus valid before enable", prevBus, EXP_TAB[i]);
      w = 0;
      steady = 1'b1;
      do begin
        @(negedge clk);
        w++;
        if (bus !== EXP_TAB[i]) steady = 1'b0;
      end while (lcdE && w < LIMIT);
      check("R7 enable width", w, EN);
      check("R8 bus held through pulse", steady, 1);
      dly = (EXP_TAB[i][9:8] == 2'b00 && EXP_TAB[i][7:0] >= 8'h01 &&
             EXP_TAB[i][7:0] <= 8'h03) ? LONG : SHORT;
      if (i < 23) begin
        countUntilE(g);
        check("R9 settle gap", g, dly + 2);
      end else begin
        g = 0;
        do begin
          @(negedge clk);
          g++;
          if (lcdE) begin
            nFails++;
            $display("FAIL R10: actual extra pulse expected none");
          end
        end while (!done && g < LIMIT);
        check("R10 done delay", g, SHORT);
      end
    end

    ePulses = 0;
    doneCnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (lcdE) ePulses++;
      if (done) doneCnt++;
    end
    check("R10 enable quiet after done", ePulses, 0);
    check("R10 done sticky", doneCnt, 40);
    check("R10 bus unchanged after done", bus, EXP_TAB[23]);

    // reset after completion
    rst = 1'b1;
    @(negedge clk);
    check("R11 done cleared by reset", done, 0);
    rst = 1'b0;
    countUntilE(n);
    check("R11 restart power-up wait", n, PWR + 2);
    check("R11 restart at entry 0", bus, EXP_TAB[0]);

    // reset in the middle of an enable pulse
    repeat (2) @(negedge clk);
    check("R11 pulse still active", lcdE, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 enable cleared mid-pulse", lcdE, 0);
    check("R1 bus cleared mid-pulse", bus, 0);
    rst = 1'b0;
    countUntilE(n);
    check("R11 mid-pulse restart wait", n, PWR + 2);
    check("R11 mid-pulse restart entry", bus, EXP_TAB[0]);

    summary();
  end

endmodule